// File: doc/BRIEF.md
# Per-Lane Event Counter Unit

This unit counts one selected event on one selected lane of a multi-lane serial link controller. The link logic supplies a flat vector of one-bit strobes, one for each event of each lane. Software programs a control word that names the event (a group and a number within that group) and the lane. The selected strobe is then added into a 32-bit count that software reads back through a small word-addressed register port.

Counting is started and stopped by a three-bit command code. The count is reset by a separate two-bit command code. Both codes act only on the cycle of the write. Disabling leaves the count in place, and so does enabling again, so one count can span several intervals of counting until software clears it. Software can change the selector while counting runs, and counting moves to the new event without losing the count already accumulated.

Strobe bit index: `((group * EVENTS_PER_GROUP) + number) * LANES + lane`.

Top module: `lane_event_counter`

## Requirements
- R1: After reset, the control word at offset 0x8 reads 0, the count at offset 0xC reads 0, and no counting takes place.
- R2: A write to offset 0x8 stores the group in bits 27:24, the event number in bits 23:16, the lane in bits 11:8, the enable code in bits 4:2 and the clear code in bits 1:0. A read returns these values in the same positions, and bits 31:28, 15:12 and 6:5 read as 0.
- R3: Enable code 3 starts counting. From the first clock edge after that write, each edge at which the selected strobe is high adds 1 to the count, modulo 2^32. Strobes of other lanes or other events add nothing.
- R4: Enable code 1 stops counting and keeps the count. Any enable code other than 1 or 3 leaves the counting state as it was.
- R5: Clear code 1 sets the count to 0 at the write edge and takes priority over an increment on that same edge. Clear codes other than 1 leave the count unchanged.
- R6: Enabling counting again after a stop does not clear the count. Counting continues from the value that was held.
- R7: Bit 7 of the control word reads 1 while counting is enabled and 0 otherwise.
- R8: The count does not increment while the lane index is at or above LANES, the group is at or above GROUPS, or the event number is at or above EVENTS_PER_GROUP.
- R9: A new selector written while counting is enabled takes effect from the next edge, and the count is not cleared.
- R10: A read asserted at one edge gives valid data, with rvalid high, in the following cycle. Writes to offset 0xC are ignored. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | High for one cycle after a read strobe |
| ev_strobe | input | GROUPS*EVENTS_PER_GROUP*LANES (256) | One-bit event strobes, one per event per lane |

## Verification
A control write registered at edge k first affects counting at edge k+1, because the enable state and the selector are registered. The one exception is a clear, which acts on edge k itself. Read data registered at edge k shows the count as it stood before that edge and appears with rvalid in the cycle after. The driver changes inputs only at falling edges and pushes the expected word into a queue when it issues a read. The monitor pops from the queue at the falling edge on which rvalid is high, so every comparison is made exactly one cycle after the read strobe was sampled. Strobe pulses are applied for a known number of rising edges, and each one ends before the following read, so the expected count is an exact number of edges.

// File: rtl/lec_pkg.sv
// Package for the per-lane event counter: register offsets, command codes
// and the field positions of the control word.
package lec_pkg;
    localparam int CTRL_OFS   = 8'h08;
    localparam int DATA_OFS   = 8'h0C;

    localparam int GRP_LSB    = 24;
    localparam int GRP_W      = 4;
    localparam int NUM_LSB    = 16;
    localparam int NUM_W      = 8;
    localparam int LANE_LSB   = 8;
    localparam int LANE_W     = 4;
    localparam int STAT_BIT   = 7;
    localparam int ENC_LSB    = 2;
    localparam int ENC_W      = 3;
    localparam int CLC_LSB    = 0;
    localparam int CLC_W      = 2;

    localparam logic [ENC_W-1:0] EN_CMD_ON  = 3'd3;
    localparam logic [ENC_W-1:0] EN_CMD_OFF = 3'd1;
    localparam logic [CLC_W-1:0] CLR_CMD    = 2'd1;

    // Registered selection state shared by the sub-blocks.
    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [NUM_W-1:0]  num;
        logic [LANE_W-1:0] lane;
    } sel_t;
endpackage

// File: rtl/lec_ctrl_reg.sv
// Control register of the event counter.
// Decodes writes to the control offset, holds the selector, the lane and the
// last written command codes, and tracks the counting state. Assumes that the
// caller presents a write strobe together with its offset and data in one cycle.
module lec_ctrl_reg
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [GRP_W-1:0]  wr_grp,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [ENC_W-1:0]  wr_enc,
    input  logic [CLC_W-1:0]  wr_clc,
    output sel_t              sel_q,
    output logic [ENC_W-1:0]  enc_q,
    output logic [CLC_W-1:0]  clc_q,
    output logic              en_q,
    output logic              clr_now
);
    logic ctrl_hit;

    // Decode a write to the control word.
    always_comb ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));

    // The clear acts on the write edge itself.
    always_comb clr_now = ctrl_hit && (wr_clc == CLR_CMD);

    // Store the selector and the command codes for readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            enc_q <= '0;
            clc_q <= '0;
        end else if (ctrl_hit) begin
            sel_q.grp  <= wr_grp;
            sel_q.num  <= wr_num;
            sel_q.lane <= wr_lane;
            enc_q      <= wr_enc;
            clc_q      <= wr_clc;
        end
    end

    // Counting state: only the on and off codes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (ctrl_hit && wr_enc == EN_CMD_ON)
            en_q <= 1'b1;
        else if (ctrl_hit && wr_enc == EN_CMD_OFF)
            en_q <= 1'b0;
    end
endmodule

// File: rtl/lec_event_sel.sv
// Event selector.
// Picks one strobe out of the flat strobe vector from the registered selector.
// Out-of-range group, number or lane gives no hit. Assumes the strobe layout
// ((group * EPG) + number) * LANES + lane.
module lec_event_sel
    import lec_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int EPG    = 8,
    parameter int LANES  = 4,
    localparam int N_EV     = GROUPS * EPG,
    localparam int STROBE_W = N_EV * LANES,
    localparam int EV_IDX_W = (N_EV > 1) ? $clog2(N_EV) : 1,
    localparam int LN_IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  sel_t                sel,
    input  logic [STROBE_W-1:0] strobes,
    output logic                hit
);
    logic             grp_ok, num_ok, lane_ok;
    logic [EV_IDX_W-1:0] ev_idx;
    logic [LN_IDX_W-1:0] ln_idx;
    logic [LANES-1:0] ev_row [N_EV];

    // Range checks on each part of the selector.
    always_comb begin
        grp_ok  = 32'(sel.grp)  < GROUPS;
        num_ok  = 32'(sel.num)  < EPG;
        lane_ok = 32'(sel.lane) < LANES;
    end

    // Split the strobe vector into one row of lane bits per event.
    for (genvar e = 0; e < N_EV; e++) begin : g_row
        assign ev_row[e] = strobes[e*LANES +: LANES];
    end

    // Flat event index and lane index, forced to 0 when out of range.
    always_comb begin
        ev_idx = '0;
        ln_idx = '0;
        if (grp_ok && num_ok)
            ev_idx = EV_IDX_W'(32'(sel.grp) * EPG + 32'(sel.num));
        if (lane_ok)
            ln_idx = LN_IDX_W'(sel.lane);
    end

    // Select the strobe only when every field is in range.
    always_comb hit = grp_ok && num_ok && lane_ok && ev_row[ev_idx][ln_idx];
endmodule

// File: rtl/lec_counter.sv
// Count accumulator.
// Holds the count and adds one on each enabled hit, modulo 2^CNT_W. A clear
// overrides an increment on the same edge. Assumes hit and enable are stable
// around the edge.
module lec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    // Clear first, then increment; the value is otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en && hit)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/lane_event_counter.sv
// Top of the per-lane event counter unit.
// Joins the control register, the event selector and the accumulator, and
// serves register reads one cycle after the read strobe. Assumes at most one
// of reg_wr and reg_rd per cycle matters for a given offset.
module lane_event_counter
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int GROUPS = 8,
    parameter int EPG    = 8,
    parameter int LANES  = 4,
    localparam int CNT_W    = 32,
    localparam int STROBE_W = GROUPS * EPG * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                reg_rvalid,
    input  logic [STROBE_W-1:0] ev_strobe
);
    sel_t             sel_q;
    logic [ENC_W-1:0] enc_q;
    logic [CLC_W-1:0] clc_q;
    logic             en_q;
    logic             clr_now;
    logic             hit;
    logic [CNT_W-1:0] count_q;
    logic [31:0]      ctrl_word;
    logic [31:0]      rd_mux;
    logic             unused_wbits;

    // Write data bits with no field behind them.
    assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[15:12], reg_wdata[7:5]};

    lec_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .wr_grp  (reg_wdata[GRP_LSB  +: GRP_W]),
        .wr_num  (reg_wdata[NUM_LSB  +: NUM_W]),
        .wr_lane (reg_wdata[LANE_LSB +: LANE_W]),
        .wr_enc  (reg_wdata[ENC_LSB  +: ENC_W]),
        .wr_clc  (reg_wdata[CLC_LSB  +: CLC_W]),
        .sel_q   (sel_q),
        .enc_q   (enc_q),
        .clc_q   (clc_q),
        .en_q    (en_q),
        .clr_now (clr_now)
    );

    lec_event_sel #(.GROUPS(GROUPS), .EPG(EPG), .LANES(LANES)) u_sel (
        .sel    (sel_q),
        .strobes(ev_strobe),
        .hit    (hit)
    );

    lec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_q),
        .hit  (hit),
        .clr  (clr_now),
        .cnt_q(count_q)
    );

    // Assemble the control word for readback.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[GRP_LSB  +: GRP_W]  = sel_q.grp;
        ctrl_word[NUM_LSB  +: NUM_W]  = sel_q.num;
        ctrl_word[LANE_LSB +: LANE_W] = sel_q.lane;
        ctrl_word[STAT_BIT]           = en_q;
        ctrl_word[ENC_LSB  +: ENC_W]  = enc_q;
        ctrl_word[CLC_LSB  +: CLC_W]  = clc_q;
    end

    // Offset decode for reads; unmapped offsets return zero.
    always_comb begin
        if (reg_addr == ADDR_W'(CTRL_OFS))
            rd_mux = ctrl_word;
        else if (reg_addr == ADDR_W'(DATA_OFS))
            rd_mux = count_q;
        else
            rd_mux = '0;
    end

    // Register the read response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/lane_event_counter_chk.sv
// Assertion checker for the per-lane event counter, bound to the top module.
// Observes ports and the registered state that the sub-blocks drive.
module lane_event_counter_chk
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              en_q,
    input logic [LANE_W-1:0] lane_q,
    input logic [31:0]       count_q
);
    logic wr_ctrl;
    logic clr_wr;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    assign clr_wr  = wr_ctrl && (reg_wdata[1:0] == CLR_CMD);

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (count_q == 32'd0)); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 32'd1)); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !clr_wr) |=> $stable(count_q)); // R4

    AST_ENABLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[4:2] == EN_CMD_ON) |=> en_q); // R3

    AST_BAD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lane_q) >= LANES && !clr_wr) |=> $stable(count_q)); // R8

    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(CTRL_OFS)) |=> (reg_rdata[7] == $past(en_q))); // R7

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R10

    AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid); // R10
endmodule

bind lane_event_counter lane_event_counter_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_rvalid(reg_rvalid),
    .en_q      (en_q),
    .lane_q    (sel_q.lane),
    .count_q   (count_q)
);

// File: tb/lane_event_counter_test.sv
// Scoreboard bench: reads push expected words, a monitor pops on rvalid.
module lane_event_counter_test;
    localparam int ADDR_W = 8;
    localparam int GROUPS = 8;
    localparam int EPG    = 8;
    localparam int LANES  = 4;
    localparam int SW     = GROUPS * EPG * LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              reg_rvalid;
    logic [SW-1:0]     ev_strobe = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    lane_event_counter #(.ADDR_W(ADDR_W), .GROUPS(GROUPS), .EPG(EPG), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ev_strobe(ev_strobe)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] cword(int g, int n, int l, int en, int cl);
        return (32'(g) << 24) | (32'(n) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(cl);
    endfunction

    function automatic int sidx(int g, int n, int l);
        return (g * EPG + n) * LANES + l;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Hold one strobe bit high across n rising edges.
    task automatic pulse(input int idx, input int n);
        @(negedge clk);
        ev_strobe[idx] = 1'b1;
        repeat (n) @(negedge clk);
        ev_strobe[idx] = 1'b0;
    endtask

    task automatic pulse_all(input int n);
        @(negedge clk);
        ev_strobe = '1;
        repeat (n) @(negedge clk);
        ev_strobe = '0;
    endtask

    // Monitor: compare each read response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected rvalid actual=%h expected=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h08, 32'h0, "R1 ctrl after reset");
        rd(8'h0C, 32'h0, "R1 count after reset");
        pulse_all(2);
        rd(8'h0C, 32'h0, "R1 no counting after reset");

        // R2 R7: program group 2, number 3, lane 1, enable, clear
        wr(8'h08, cword(2, 3, 1, 3, 1) | 32'hF000_F060);
        rd(8'h08, cword(2, 3, 1, 3, 1) | 32'h80, "R2 R7 ctrl readback enabled");

        // R3: five selected strobes, then a neighbouring lane
        pulse(sidx(2, 3, 1), 5);
        rd(8'h0C, 32'd5, "R3 selected strobe count");
        pulse(sidx(2, 3, 0), 3);
        pulse(sidx(2, 2, 1), 2);
        rd(8'h0C, 32'd5, "R3 other lane or event ignored");

        // R4 R7: stop keeps the count
        wr(8'h08, cword(2, 3, 1, 1, 0));
        pulse(sidx(2, 3, 1), 4);
        rd(8'h0C, 32'd5, "R4 stopped count held");
        rd(8'h08, cword(2, 3, 1, 1, 0), "R7 status low when stopped");
        wr(8'h08, cword(2, 3, 1, 0, 0));
        pulse(sidx(2, 3, 1), 2);
        rd(8'h0C, 32'd5, "R4 code 0 keeps stopped");

        // R6: resume without clearing
        wr(8'h08, cword(2, 3, 1, 3, 0));
        pulse(sidx(2, 3, 1), 3);
        rd(8'h0C, 32'd8, "R6 resume keeps count");

        // R4: other code keeps running
        wr(8'h08, cword(2, 3, 1, 2, 0));
        pulse(sidx(2, 3, 1), 1);
        rd(8'h0C, 32'd9, "R4 code 2 keeps running");

        // R5: clear code 2 has no effect
        wr(8'h08, cword(2, 3, 1, 0, 2));
        pulse(sidx(2, 3, 1), 1);
        rd(8'h0C, 32'd10, "R5 clear code 2 ignored");

        // R5: clear beats increment on the same edge
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = cword(2, 3, 1, 0, 1);
        ev_strobe[sidx(2, 3, 1)] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        ev_strobe = '0;
        rd(8'h0C, 32'd0, "R5 clear wins over increment");
        pulse(sidx(2, 3, 1), 2);
        rd(8'h0C, 32'd2, "R5 counting after clear");

        // R8: out-of-range lane, group and number
        wr(8'h08, cword(2, 3, 5, 3, 1));
        pulse_all(3);
        rd(8'h0C, 32'd0, "R8 lane out of range");
        wr(8'h08, cword(9, 0, 0, 3, 0));
        pulse_all(3);
        rd(8'h0C, 32'd0, "R8 group out of range");
        wr(8'h08, cword(1, 12, 0, 3, 0));
        pulse_all(3);
        rd(8'h0C, 32'd0, "R8 number out of range");

        // R9: redirect while running keeps the count
        wr(8'h08, cword(0, 0, 0, 3, 1));
        pulse(sidx(0, 0, 0), 2);
        rd(8'h0C, 32'd2, "R9 first event counted");
        wr(8'h08, cword(7, 7, 3, 0, 0));
        pulse(sidx(0, 0, 0), 2);
        pulse(sidx(7, 7, 3), 3);
        rd(8'h0C, 32'd5, "R9 redirected without clear");

        // R10: count is read-only, unmapped reads give zero
        wr(8'h0C, 32'hDEAD_BEEF);
        rd(8'h0C, 32'd5, "R10 write to count ignored");
        rd(8'h04, 32'd0, "R10 unmapped offset reads zero");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule